// File: doc/BRIEF.md
# Chained grayscale clock and blank timer

This block drives the two timing signals that a constant-current LED driver with an internal grayscale counter needs: a free-running grayscale clock, and a periodic blank pulse that restarts that counter after a programmed number of grayscale clock rising edges. The block is built from two counters in a chain. The first counter runs from a prescaled system clock and counts up to a programmable reload value. Each time it wraps it emits a one-cycle trigger, and a compare on its count toggles the grayscale clock. The second counter never sees the system clock tick on its own. It steps only on that trigger and sweeps up to a peak and back down to zero. The blank output is raised while this counter sits at its peak.

Software, or a surrounding controller, sets the prescaler, the first counter's reload value and the wanted pulse count N, then raises the enable. The second counter's peak is taken from N. One up/down sweep then lasts exactly as long as N grayscale periods. All settings are held in shadow copies. New values take effect only at a period boundary, so a change never produces a short or stretched period.

Top module: `gray_blank_timer`

## Requirements
- R1: A synchronous active-high reset clears both counters and drives the grayscale clock, the trigger and the blank output low on the next clock edge. This holds whatever the enable is.
- R2: With prescaler value P and reload value A, the trigger rises once every T = (P+1)*(A+1) clock cycles.
- R3: Each trigger pulse is high for exactly one clock cycle.
- R4: The grayscale clock toggles once per trigger period. It toggles when the first counter steps from 0 to 1, and never in the cycle in which the trigger is high. Its rising edges are therefore 2*T cycles apart, and it stays high for T cycles.
- R5: The second counter moves only on trigger pulses. It counts from 0 up to N and then back down to 0. The blank output is high while that counter equals N, so blank is high for T cycles and rises every 2*N*T cycles.
- R6: Between two consecutive blank rising edges there are exactly N grayscale clock rising edges. An edge that falls in the same cycle as a blank rising edge is counted with the interval that this blank edge ends.
- R7: A reload value of 0 is treated as 1, and a pulse count of 0 is treated as 1.
- R8: A new prescaler or reload value applied while running first takes effect in the trigger period that begins after the next update event. The period already in progress keeps the old values.
- R9: A new pulse count applied while running is taken only when the second counter leaves 0 on its way up. The sweep in progress keeps its old peak.
- R10: While the enable is low, all outputs are low and the shadows follow the inputs. After the enable rises, the first grayscale rising edge comes P+1 cycles later and the first trigger comes T cycles later. Lowering the enable returns all outputs to low on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds both counters at zero |
| psc_i | input | PSC_W | Prescaler value P; the counter clock is clk divided by P+1 |
| reload_i | input | ARR_W | Reload value A of the first counter (0 is treated as 1) |
| pulses_i | input | CNT_W | Grayscale edges N per blank period (0 is treated as 1) |
| gray_clk_o | output | 1 | Grayscale clock |
| blank_o | output | 1 | Blank pulse, high while the second counter is at its peak |
| trig_o | output | 1 | One-cycle update trigger of the first counter |

## Verification
Several rules are checked by the assertions on every cycle. The trigger is never longer than one cycle. The grayscale clock never toggles in the same cycle as the trigger. The blank output changes only in the cycle after a trigger. The second counter never climbs past its latched peak. Outputs stay low while the enable is off. The bench scenarios are needed for everything that is counted over whole periods. These are the exact trigger, grayscale and blank periods and widths for each setting, the number of grayscale edges per blank period, and the phase after the enable rises. They also cover the delayed effect of prescaler, reload and pulse-count changes made while the block runs.

// File: rtl/graytmr_pkg.sv
package graytmr_pkg;

    // Value the first counter must step into for the grayscale clock to toggle.
    localparam int GRAY_CMP = 1;

    // Sweep direction of the second counter.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;

    // Events produced by the first counter in one cycle.
    typedef struct packed {
        logic tick;     // counter clock enable from the prescaler
        logic update;   // counter wraps at its reload value
        logic toggle;   // counter steps into the compare value
    } master_evt_t;

endpackage

// File: rtl/graytmr_prescaler.sv
module graytmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] div_cnt;
    logic [PSC_W-1:0] psc_sh;

    assign tick_o = run && (div_cnt == psc_sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            psc_sh  <= '0;
        end else if (!run) begin
            div_cnt <= '0;
            psc_sh  <= psc_i;
        end else begin
            if (tick_o) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
            if (load) begin
                psc_sh <= psc_i;
            end
        end
    end

endmodule

// File: rtl/graytmr_master.sv
module graytmr_master
    import graytmr_pkg::*;
#(
    parameter int ARR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [ARR_W-1:0] reload_i,
    output logic             update_o,
    output logic             trig_o,
    output logic             gray_o
);

    logic [ARR_W-1:0] cnt_q;
    logic [ARR_W-1:0] cnt_nxt;
    logic [ARR_W-1:0] arr_sh;
    logic [ARR_W-1:0] reload_eff;
    master_evt_t      evt;

    assign reload_eff = (reload_i == '0) ? ARR_W'(1) : reload_i;

    always_comb begin
        evt.tick   = tick;
        evt.update = tick && (cnt_q == arr_sh);
        cnt_nxt    = evt.update ? '0 : cnt_q + 1'b1;
        evt.toggle = tick && (cnt_nxt == ARR_W'(GRAY_CMP));
    end

    assign update_o = evt.update;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            arr_sh <= ARR_W'(1);
            trig_o <= 1'b0;
            gray_o <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            arr_sh <= reload_eff;
            trig_o <= 1'b0;
            gray_o <= 1'b0;
        end else begin
            trig_o <= evt.update;
            if (evt.tick) begin
                cnt_q <= cnt_nxt;
            end
            if (evt.update) begin
                arr_sh <= reload_eff;
            end
            if (evt.toggle) begin
                gray_o <= ~gray_o;
            end
        end
    end

endmodule

// File: rtl/graytmr_slave.sv
module graytmr_slave
    import graytmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] pulses_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] top_o,
    output logic             blank_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_sh;
    logic [CNT_W-1:0] pulses_eff;
    logic [CNT_W-1:0] limit;
    sweep_dir_e       dir_q;

    assign pulses_eff = (pulses_i == '0) ? CNT_W'(1) : pulses_i;
    assign limit      = (cnt_q == '0) ? pulses_eff : top_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            top_sh <= CNT_W'(1);
            dir_q  <= DIR_UP;
        end else if (!run) begin
            cnt_q  <= '0;
            top_sh <= pulses_eff;
            dir_q  <= DIR_UP;
        end else if (step) begin
            if (dir_q == DIR_UP) begin
                if (cnt_q == '0) begin
                    top_sh <= pulses_eff;
                end
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q + 1'b1 == limit) begin
                    dir_q <= DIR_DOWN;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    dir_q <= DIR_UP;
                end
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign top_o   = top_sh;
    assign blank_o = (cnt_q >= top_sh);

endmodule

// File: rtl/gray_blank_timer.sv
module gray_blank_timer #(
    parameter int PSC_W = 16,
    parameter int ARR_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [ARR_W-1:0] reload_i,
    input  logic [CNT_W-1:0] pulses_i,
    output logic             gray_clk_o,
    output logic             blank_o,
    output logic             trig_o
);

    logic             tick;
    logic             update;
    logic             trig;
    logic [CNT_W-1:0] slv_cnt;
    logic [CNT_W-1:0] slv_top;

    graytmr_prescaler #(.PSC_W(PSC_W)) i_prescaler (
        .clk    (clk),
        .rst    (rst),
        .run    (en),
        .load   (update),
        .psc_i  (psc_i),
        .tick_o (tick)
    );

    graytmr_master #(.ARR_W(ARR_W)) i_master (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .tick     (tick),
        .reload_i (reload_i),
        .update_o (update),
        .trig_o   (trig),
        .gray_o   (gray_clk_o)
    );

    graytmr_slave #(.CNT_W(CNT_W)) i_slave (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .step     (trig),
        .pulses_i (pulses_i),
        .cnt_o    (slv_cnt),
        .top_o    (slv_top),
        .blank_o  (blank_o)
    );

    assign trig_o = trig;

endmodule

// File: rtl/gray_blank_timer_chk.sv
module gray_blank_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             trig_o,
    input logic             gray_clk_o,
    input logic             blank_o,
    input logic [CNT_W-1:0] slv_cnt,
    input logic [CNT_W-1:0] slv_top
);

    // R3: trigger never lasts two cycles
    p_trig_single_r3: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    // R4: grayscale clock never toggles together with the trigger
    p_gray_apart_r4: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(gray_clk_o)) |-> !trig_o);

    // R5: blank only changes right after a trigger
    p_blank_on_step_r5: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(blank_o)) |-> $past(trig_o));

    // R5: second counter stays within its latched peak
    p_slave_bound_r5: assert property (@(posedge clk) disable iff (rst)
        slv_cnt <= slv_top);

    // R10: disabled block is quiet on the next edge
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!trig_o && !gray_clk_o && !blank_o));

endmodule

bind gray_blank_timer gray_blank_timer_chk #(.CNT_W(CNT_W)) i_gray_blank_timer_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .trig_o     (trig_o),
    .gray_clk_o (gray_clk_o),
    .blank_o    (blank_o),
    .slv_cnt    (slv_cnt),
    .slv_top    (slv_top)
);

// File: tb/test_gray_blank_timer.sv
`timescale 1ns/1ps
module test_gray_blank_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] psc = '0;
    logic [15:0] arr = 16'd1;
    logic [15:0] ngs = 16'd1;
    logic        gray, blank, trig;

    int tests = 0;
    int fails = 0;

    // Per-category bookkeeping for the table walk.
    int nseen [7];
    int nbad  [7];
    int bact  [7];
    int bexp  [7];
    string cname [7] = '{"R2 trigger period", "R3 trigger width", "R4 gray period",
                         "R4 gray high time", "R5 blank high time", "R5 blank period",
                         "R6 gray edges per blank"};

    // psc, reload, pulses, expected T, expected effective N
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{0, 1, 2, 2, 2},
        '{1, 1, 4, 4, 4},
        '{0, 3, 1, 4, 1},
        '{2, 2, 3, 9, 3},
        '{0, 0, 0, 2, 1},   // R7: zero reload and zero count clamp to 1
        '{3, 1, 5, 8, 5}
    };

    always #4 clk = ~clk;

    gray_blank_timer i_gray_blank_timer (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .psc_i      (psc),
        .reload_i   (arr),
        .pulses_i   (ngs),
        .gray_clk_o (gray),
        .blank_o    (blank),
        .trig_o     (trig)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic note(input int k, input int act, input int exp);
        nseen[k]++;
        if (act != exp) begin
            if (nbad[k] == 0) begin
                bact[k] = act;
                bexp[k] = exp;
            end
            nbad[k]++;
        end
    endtask

    task automatic run_vec(input int p, input int a, input int n, input int et, input int ee);
        int  w;
        int  tr, gr, br, edges, first_g, first_t;
        bit  pt, pg, pb;
        for (int k = 0; k < 7; k++) begin
            nseen[k] = 0; nbad[k] = 0; bact[k] = 0; bexp[k] = 0;
        end
        en = 1'b0; psc = 16'(p); arr = 16'(a); ngs = 16'(n);
        @(negedge clk); @(negedge clk);
        en = 1'b1;
        w = 6 * ee * et + 4 * et;
        tr = -1; gr = -1; br = -1; edges = 0; first_g = -1; first_t = -1;
        pt = 1'b0; pg = 1'b0; pb = 1'b0;
        for (int c = 1; c <= w; c++) begin
            @(negedge clk);
            if (gray && !pg) begin
                if (first_g < 0) first_g = c;
                if (gr >= 0) note(2, c - gr, 2 * et);
                gr = c;
                edges++;
            end
            if (!gray && pg && gr >= 0) note(3, c - gr, et);
            if (trig && !pt) begin
                if (first_t < 0) first_t = c;
                if (tr >= 0) note(0, c - tr, et);
                tr = c;
            end
            if (!trig && pt) note(1, c - tr, 1);
            if (blank && !pb) begin
                if (br >= 0) begin
                    note(5, c - br, 2 * ee * et);
                    note(6, edges, ee);
                end
                br = c;
                edges = 0;
            end
            if (!blank && pb && br >= 0) note(4, c - br, et);
            pt = trig; pg = gray; pb = blank;
        end
        check(first_g == p + 1, "R10 first gray rise after enable", first_g, p + 1);
        check(first_t == et, "R10 first trigger after enable", first_t, et);
        for (int k = 0; k < 7; k++) begin
            if (nseen[k] < 2)
                check(1'b0, cname[k], nseen[k], 2);
            else
                check(nbad[k] == 0, cname[k], bact[k], bexp[k]);
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    // Gaps between the next two rising edges of the trigger (sel=0) or blank (sel=1).
    task automatic two_gaps(input bit sel, output int g1, output int g2);
        bit prev;
        int last, seen;
        prev = sel ? blank : trig;
        last = 0; seen = 0; g1 = -1; g2 = -1;
        for (int c = 1; c <= 400 && seen < 2; c++) begin
            @(negedge clk);
            if ((sel ? blank : trig) && !prev) begin
                if (seen == 0) g1 = c; else g2 = c - last;
                last = c;
                seen++;
            end
            prev = sel ? blank : trig;
        end
    endtask

    task automatic wait_rise(input bit sel);
        bit prev;
        prev = sel ? blank : trig;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if ((sel ? blank : trig) && !prev) break;
            prev = sel ? blank : trig;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int g1, g2, highs;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({gray, trig, blank} == 3'b000, "R1 outputs low in reset", {gray, trig, blank}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
        end

        // R8: prescaler and reload changes wait for the next update event
        en = 1'b0; psc = 16'd0; arr = 16'd3; ngs = 16'd2;
        @(negedge clk); @(negedge clk);
        en = 1'b1;
        wait_rise(1'b0);
        psc = 16'd2; arr = 16'd1;
        two_gaps(1'b0, g1, g2);
        check(g1 == 4, "R8 period in progress keeps old setting", g1, 4);
        check(g2 == 6, "R8 new setting after update event", g2, 6);

        // R9: pulse-count change waits for the sweep to leave zero
        en = 1'b0; psc = 16'd0; arr = 16'd1; ngs = 16'd2;
        @(negedge clk); @(negedge clk);
        en = 1'b1;
        wait_rise(1'b1);
        ngs = 16'd3;
        two_gaps(1'b1, g1, g2);
        check(g1 == 10, "R9 blank gap across count change", g1, 10);
        check(g2 == 12, "R9 blank period with new count", g2, 12);

        // R10: disable returns outputs low and keeps them there
        en = 1'b0;
        @(negedge clk);
        check({gray, trig, blank} == 3'b000, "R10 outputs low after disable", {gray, trig, blank}, 0);
        highs = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (gray || trig || blank) highs++;
        end
        check(highs == 0, "R10 outputs stay low while disabled", highs, 0);

        // R1: reset while running
        psc = 16'd0; arr = 16'd1; ngs = 16'd1;
        en = 1'b1;
        repeat (13) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check({gray, trig, blank} == 3'b000, "R1 reset clears outputs while enabled", {gray, trig, blank}, 0);
        highs = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (gray || trig || blank) highs++;
        end
        check(highs == 0, "R1 outputs held low during reset", highs, 0);
        rst = 1'b0;
        en = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule